// File: doc/BRIEF.md
# Fault Confinement Error Counter Unit

This block keeps the two error counters of a node on a multi-master serial bus with dominant and recessive levels. One counter tracks transmit-side errors and the other tracks receive-side errors. From those counters it derives the node's confinement state: error-active, error-passive or bus-off. The protocol engine drives single-cycle event pulses into the block. These report detected errors, bit errors while a flag is being driven, a dominant bit seen right after an error flag, and successful transmissions and receptions. The engine also supplies a per-bit strobe with the sampled bus level.

The block counts long dominant runs that follow a flag and adds the heavy penalty to both counters. While the node is bus-off, it counts runs of recessive bits and clears both counters once enough runs have been seen. It also tells the engine whether an error flag is dominant or recessive, whether transmission is inhibited, and whether the node is inside its post-transmission suspension window.

All events that arrive in one clock cycle are merged into a single arithmetic update. The state outputs are registered from the updated counter values, so every output reflects an event after the clock edge at which the event was sampled.

Top module: `fault_confinement_unit`

## Requirements
- R1: After reset both counters read 0, `node_state` is 0 (active), `flag_dominant` is 1, and `tx_inhibit` and `suspend_tx` are 0.
- R2: `node_state` encodes active=0, passive=1, bus-off=2. The node is bus-off when the transmit counter exceeds 255. Otherwise it is passive when either counter exceeds 127, and active when neither does.
- R3: `rx_err_evt` adds 1 to the receive counter. When `flag_biterr_evt` is high in the same cycle, this +1 is dropped.
- R4: `rx_dom_after_flag` adds 8 to the receive counter and `tx_err_evt` adds 8 to the transmit counter. `flag_biterr_evt` adds 8 to the transmit counter when `is_tx` is 1 and to the receive counter when `is_tx` is 0.
- R5: After a `run_arm_act` pulse, the 14th consecutive dominant bit strobe adds 8 to both counters, and so does each further 8th dominant strobe. A recessive strobe ends the run.
- R6: After a `run_arm_pas` pulse, the 8th consecutive dominant bit strobe adds 8 to both counters, and so does every further 8th.
- R7: `tx_ok_evt` lowers the transmit counter by 1 and leaves it at 0 if it is 0. `rx_ok_evt` sets the receive counter to 127 if it was above 127, leaves it at 0 if it was 0, and otherwise lowers it by 1.
- R8: Events in the same cycle are combined into one update that is visible after that clock edge. The receive counter saturates at 255, and the transmit counter saturates at its all-ones value.
- R9: While bus-off, `tx_inhibit` is 1 and error or success events leave both counters unchanged. After 128 runs of 11 consecutive recessive bit strobes, both counters clear and the node returns to active. A dominant strobe restarts the current run.
- R10: `flag_dominant` is 1 only in the active state.
- R11: An `own_tx_end` pulse while the node is passive raises `suspend_tx` for the next 8 recessive bit strobes. A dominant strobe ends the window early. In the active state the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One pulse per bus bit, qualifies `rx_bit` |
| rx_bit | input | 1 | Sampled bus level, 0 = dominant |
| is_tx | input | 1 | Node is currently the transmitter |
| rx_err_evt | input | 1 | Error detected as receiver |
| tx_err_evt | input | 1 | Error detected as transmitter (+8 rule) |
| flag_biterr_evt | input | 1 | Bit error while driving an active or overload flag |
| rx_dom_after_flag | input | 1 | Dominant bit first after own error flag as receiver |
| tx_ok_evt | input | 1 | Successful transmission |
| rx_ok_evt | input | 1 | Successful reception |
| run_arm_act | input | 1 | Start dominant-run watch at an active/overload flag |
| run_arm_pas | input | 1 | Start dominant-run watch after a passive flag |
| own_tx_end | input | 1 | Own frame and intermission finished |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| node_state | output | 2 | Confinement state |
| flag_dominant | output | 1 | Error flag to send is dominant |
| tx_inhibit | output | 1 | Transmission forbidden (bus-off) |
| suspend_tx | output | 1 | Suspension window active |

## Verification
The bench builds the block with its default parameters: a 9-bit transmit counter, an 8-bit receive counter, a 14/8-bit dominant-run schedule, a recovery of 128 runs of 11 bits, and 8 suspension bits. With these defaults, the real thresholds of 127 and 255 are crossed one step at a time, receive-counter saturation at 255 is reached with 32 heavy penalties, and the full 1408-bit recovery fits inside a short run. The tests probe the exact strobe at which each dominant-run penalty and the recovery fire, by checking one strobe before and at the boundary.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;

  typedef struct packed {
    logic rx_err;
    logic tx_err;
    logic flag_biterr;
    logic rx_dom_after;
    logic tx_ok;
    logic rx_ok;
  } fc_evt_t;
endpackage

// File: rtl/fc_run_counter.sv
module fc_run_counter #(
  parameter int ACT_FIRST = 14,
  parameter int PAS_FIRST = 8,
  parameter int STEP      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic arm_act,
  input  logic arm_pas,
  output logic hit
);
  localparam int M1 = (ACT_FIRST > PAS_FIRST) ? ACT_FIRST : PAS_FIRST;
  localparam int MX = (M1 > STEP) ? M1 : STEP;
  localparam int CW = $clog2(MX + 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d, thr_q, thr_d;
  logic          dom_bit;

  always_comb begin
    dom_bit = bit_stb & ~rx_bit;
    hit     = armed_q & dom_bit & ((cnt_q + CW'(1)) == thr_q);
    armed_d = armed_q;
    cnt_d   = cnt_q;
    thr_d   = thr_q;
    if (arm_act) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      thr_d   = CW'(ACT_FIRST);
    end else if (arm_pas) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      thr_d   = CW'(PAS_FIRST);
    end else if (armed_q && bit_stb) begin
      if (rx_bit) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end else if (hit) begin
        cnt_d = '0;
        thr_d = CW'(STEP);
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      thr_q   <= '0;
    end else if (arm_act || arm_pas || bit_stb) begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      thr_q   <= thr_d;
    end
  end
endmodule

// File: rtl/fc_recovery_counter.sv
module fc_recovery_counter #(
  parameter int RUN_LEN = 11,
  parameter int RUN_CNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic done
);
  localparam int RW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam int OW = (RUN_CNT > 1) ? $clog2(RUN_CNT) : 1;

  logic [RW-1:0] run_q, run_d;
  logic [OW-1:0] occ_q, occ_d;
  logic          run_end;

  always_comb begin
    run_end = enable & bit_stb & rx_bit & (run_q == RW'(RUN_LEN - 1));
    done    = run_end & (occ_q == OW'(RUN_CNT - 1));
    run_d   = run_q;
    occ_d   = occ_q;
    if (!enable) begin
      run_d = '0;
      occ_d = '0;
    end else if (bit_stb) begin
      if (!rx_bit) begin
        run_d = '0;
      end else if (run_end) begin
        run_d = '0;
        occ_d = done ? '0 : occ_q + OW'(1);
      end else begin
        run_d = run_q + RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (!enable || bit_stb) begin
      run_q <= run_d;
      occ_q <= occ_d;
    end
  end
endmodule

// File: rtl/fc_suspend_timer.sv
module fc_suspend_timer #(
  parameter int SUSP_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic bit_stb,
  input  logic rx_bit,
  output logic active
);
  localparam int SW = $clog2(SUSP_BITS + 1);

  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = SW'(SUSP_BITS);
    end else if (bit_stb && cnt_q != '0) begin
      cnt_d = rx_bit ? cnt_q - SW'(1) : '0;
    end
    active = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || bit_stb) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fc_counter_core.sv
module fc_counter_core
  import fc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int HEAVY_INC   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fc_evt_t          evt,
  input  logic             is_tx,
  input  logic             run_hit,
  input  logic             recov,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output fc_state_e        state
);
  localparam int TXW = TEC_W + 2;
  localparam int RXW = REC_W + 2;
  localparam logic [TXW-1:0] TEC_MAX = TXW'((1 << TEC_W) - 1);
  localparam logic [RXW-1:0] REC_MAX = RXW'((1 << REC_W) - 1);

  logic [TEC_W-1:0] tec_q, tec_d;
  logic [REC_W-1:0] rec_q, rec_d;
  fc_state_e        state_q, state_d;
  logic [TXW-1:0]   tec_base, tec_add, tec_sum;
  logic [RXW-1:0]   rec_base, rec_add, rec_sum;
  logic             upd_en;

  always_comb begin
    tec_base = TXW'(tec_q);
    if (evt.tx_ok && tec_q != '0) tec_base = tec_base - TXW'(1);
    tec_add = '0;
    if (evt.tx_err)                tec_add = tec_add + TXW'(HEAVY_INC);
    if (evt.flag_biterr && is_tx)  tec_add = tec_add + TXW'(HEAVY_INC);
    if (run_hit)                   tec_add = tec_add + TXW'(HEAVY_INC);
    tec_sum = tec_base + tec_add;

    rec_base = RXW'(rec_q);
    if (evt.rx_ok) begin
      if (RXW'(rec_q) > RXW'(PASSIVE_LIM)) rec_base = RXW'(PASSIVE_LIM);
      else if (rec_q != '0)                rec_base = rec_base - RXW'(1);
    end
    rec_add = '0;
    if (evt.rx_err && !evt.flag_biterr) rec_add = rec_add + RXW'(1);
    if (evt.rx_dom_after)               rec_add = rec_add + RXW'(HEAVY_INC);
    if (evt.flag_biterr && !is_tx)      rec_add = rec_add + RXW'(HEAVY_INC);
    if (run_hit)                        rec_add = rec_add + RXW'(HEAVY_INC);
    rec_sum = rec_base + rec_add;

    tec_d = (tec_sum > TEC_MAX) ? TEC_MAX[TEC_W-1:0] : tec_sum[TEC_W-1:0];
    rec_d = (rec_sum > REC_MAX) ? REC_MAX[REC_W-1:0] : rec_sum[REC_W-1:0];

    if (state_q == FC_BUSOFF) begin
      tec_d = tec_q;
      rec_d = rec_q;
      if (recov) begin
        tec_d = '0;
        rec_d = '0;
      end
    end

    if (TXW'(tec_d) > TXW'(BUSOFF_LIM))
      state_d = FC_BUSOFF;
    else if (TXW'(tec_d) > TXW'(PASSIVE_LIM) || RXW'(rec_d) > RXW'(PASSIVE_LIM))
      state_d = FC_PASSIVE;
    else
      state_d = FC_ACTIVE;

    upd_en = (|evt) | run_hit | recov;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q   <= '0;
      rec_q   <= '0;
      state_q <= FC_ACTIVE;
    end else if (upd_en) begin
      tec_q   <= tec_d;
      rec_q   <= rec_d;
      state_q <= state_d;
    end
  end

  assign tec   = tec_q;
  assign rec   = rec_q;
  assign state = state_q;
endmodule

// File: rtl/fault_confinement_unit.sv
module fault_confinement_unit
  import fc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 127,
  parameter int BUSOFF_LIM  = 255,
  parameter int HEAVY_INC   = 8,
  parameter int ACT_FIRST   = 14,
  parameter int PAS_FIRST   = 8,
  parameter int RUN_STEP    = 8,
  parameter int RECOV_LEN   = 11,
  parameter int RECOV_CNT   = 128,
  parameter int SUSP_BITS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             is_tx,
  input  logic             rx_err_evt,
  input  logic             tx_err_evt,
  input  logic             flag_biterr_evt,
  input  logic             rx_dom_after_flag,
  input  logic             tx_ok_evt,
  input  logic             rx_ok_evt,
  input  logic             run_arm_act,
  input  logic             run_arm_pas,
  input  logic             own_tx_end,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic [1:0]       node_state,
  output logic             flag_dominant,
  output logic             tx_inhibit,
  output logic             suspend_tx
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  fc_evt_t    evt;
  fc_state_e  state;
  logic       run_hit, recov;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    evt.rx_err       = rx_err_evt;
    evt.tx_err       = tx_err_evt;
    evt.flag_biterr  = flag_biterr_evt;
    evt.rx_dom_after = rx_dom_after_flag;
    evt.tx_ok        = tx_ok_evt;
    evt.rx_ok        = rx_ok_evt;
  end

  fc_run_counter #(
    .ACT_FIRST(ACT_FIRST), .PAS_FIRST(PAS_FIRST), .STEP(RUN_STEP)
  ) u_run (
    .clk(clk), .rst_n(rst_n_int), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .arm_act(run_arm_act), .arm_pas(run_arm_pas), .hit(run_hit)
  );

  fc_recovery_counter #(
    .RUN_LEN(RECOV_LEN), .RUN_CNT(RECOV_CNT)
  ) u_recov (
    .clk(clk), .rst_n(rst_n_int), .enable(state == FC_BUSOFF),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .done(recov)
  );

  fc_suspend_timer #(
    .SUSP_BITS(SUSP_BITS)
  ) u_susp (
    .clk(clk), .rst_n(rst_n_int), .load(own_tx_end && state == FC_PASSIVE),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .active(suspend_tx)
  );

  fc_counter_core #(
    .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_LIM(PASSIVE_LIM),
    .BUSOFF_LIM(BUSOFF_LIM), .HEAVY_INC(HEAVY_INC)
  ) u_core (
    .clk(clk), .rst_n(rst_n_int), .evt(evt), .is_tx(is_tx),
    .run_hit(run_hit), .recov(recov), .tec(tec), .rec(rec), .state(state)
  );

  assign node_state    = state;
  assign flag_dominant = (state == FC_ACTIVE);
  assign tx_inhibit    = (state == FC_BUSOFF);
endmodule

// File: rtl/fc_unit_chk.sv
module fc_unit_chk #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 127
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TEC_W-1:0] tec,
  input logic [REC_W-1:0] rec,
  input logic [1:0]       node_state,
  input logic             tx_inhibit,
  input logic             suspend_tx
);
  // R2
  active_limits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    node_state == 2'd0 |-> (32'(tec) <= PASSIVE_LIM && 32'(rec) <= PASSIVE_LIM));

  // R9
  busoff_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_inhibit) && tx_inhibit) |-> ($stable(tec) && $stable(rec)));

  // R9
  recovery_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_inhibit) |-> (tec == '0 && rec == '0));

  // R7
  tec_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tx_inhibit) && !tx_inhibit) |-> (32'(tec) + 1 >= 32'($past(tec))));

  // R11
  suspend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_tx) |-> $past(node_state) == 2'd1);
endmodule

bind fault_confinement_unit fc_unit_chk #(
  .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_LIM(PASSIVE_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tec(tec), .rec(rec), .node_state(node_state),
  .tx_inhibit(tx_inhibit), .suspend_tx(suspend_tx)
);

// File: tb/sim_fault_confinement_unit.sv
module sim_fault_confinement_unit;
  logic       clk, rst_n, bit_stb, rx_bit, is_tx;
  logic       rx_err_evt, tx_err_evt, flag_biterr_evt, rx_dom_after_flag;
  logic       tx_ok_evt, rx_ok_evt, run_arm_act, run_arm_pas, own_tx_end;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] node_state;
  logic       flag_dominant, tx_inhibit, suspend_tx;
  int         n_chk, n_fail;

  fault_confinement_unit u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit), .is_tx(is_tx),
    .rx_err_evt(rx_err_evt), .tx_err_evt(tx_err_evt),
    .flag_biterr_evt(flag_biterr_evt), .rx_dom_after_flag(rx_dom_after_flag),
    .tx_ok_evt(tx_ok_evt), .rx_ok_evt(rx_ok_evt), .run_arm_act(run_arm_act),
    .run_arm_pas(run_arm_pas), .own_tx_end(own_tx_end), .tec(tec), .rec(rec),
    .node_state(node_state), .flag_dominant(flag_dominant),
    .tx_inhibit(tx_inhibit), .suspend_tx(suspend_tx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    bit_stb = 0; rx_bit = 1; rx_err_evt = 0; tx_err_evt = 0;
    flag_biterr_evt = 0; rx_dom_after_flag = 0; tx_ok_evt = 0; rx_ok_evt = 0;
    run_arm_act = 0; run_arm_pas = 0; own_tx_end = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1; rx_bit = v;
      tick();
    end
  endtask

  task automatic do_reset();
    clr(); is_tx = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0); chk("R1 state", node_state, 0);
    chk("R1 flag_dominant", flag_dominant, 1); chk("R1 tx_inhibit", tx_inhibit, 0);
    chk("R1 suspend_tx", suspend_tx, 0);
  endtask

  task automatic t_rx_rules();
    do_reset();
    repeat (3) begin rx_err_evt = 1; tick(); end
    chk("R3 rec +1 x3", rec, 3);
    rx_err_evt = 1; flag_biterr_evt = 1; tick();
    chk("R3 +1 dropped with flag bit error, R4 +8", rec, 11);
    rx_dom_after_flag = 1; tick();
    chk("R4 dominant after flag", rec, 19);
    rx_ok_evt = 1; tick();
    chk("R7 rx ok decrement", rec, 18);
    chk("R4 tec untouched by receiver events", tec, 0);
  endtask

  task automatic t_tx_rules();
    do_reset(); is_tx = 1;
    tx_err_evt = 1; tick();
    chk("R4 tx error +8", tec, 8);
    flag_biterr_evt = 1; tick();
    chk("R4 flag bit error as tx", tec, 16);
    chk("R4 rec untouched", rec, 0);
    repeat (16) begin tx_ok_evt = 1; tick(); end
    chk("R7 tec down to 0", tec, 0);
    tx_ok_evt = 1; tick();
    chk("R7 tec floor at 0", tec, 0);
  endtask

  task automatic t_combined();
    do_reset(); is_tx = 1;
    tx_err_evt = 1; rx_err_evt = 1; rx_dom_after_flag = 1; tick();
    chk("R8 combined tec", tec, 8);
    chk("R8 combined rec", rec, 9);
  endtask

  task automatic t_passive_clamp();
    do_reset();
    repeat (15) begin rx_dom_after_flag = 1; tick(); end
    chk("R2 rec 120 still active", node_state, 0);
    rx_err_evt = 1; tick();
    rx_err_evt = 1; tick();
    rx_err_evt = 1; tick();
    rx_err_evt = 1; tick();
    rx_err_evt = 1; tick();
    rx_err_evt = 1; tick();
    rx_err_evt = 1; tick();
    chk("R2 rec 127 active", node_state, 0);
    rx_err_evt = 1; tick();
    chk("R2 rec 128 passive", node_state, 1);
    chk("R10 passive flag recessive", flag_dominant, 0);
    repeat (5) begin rx_dom_after_flag = 1; tick(); end
    chk("R2 rec 168", rec, 168);
    rx_ok_evt = 1; tick();
    chk("R7 clamp to 127", rec, 127);
    chk("R2 back to active", node_state, 0);
    chk("R10 active flag dominant", flag_dominant, 1);
    do_reset();
    rx_ok_evt = 1; tick();
    chk("R7 rec stays 0", rec, 0);
  endtask

  task automatic t_rec_saturate();
    do_reset();
    repeat (32) begin rx_dom_after_flag = 1; tick(); end
    chk("R8 rec saturates", rec, 255);
    rx_err_evt = 1; tick();
    chk("R8 rec held at max", rec, 255);
    chk("R2 rec max passive not busoff", node_state, 1);
  endtask

  task automatic t_run_active();
    do_reset();
    run_arm_act = 1; tick();
    bits(13, 0);
    chk("R5 no penalty at 13", tec, 0);
    bits(1, 0);
    chk("R5 penalty at 14 tec", tec, 8);
    chk("R5 penalty at 14 rec", rec, 8);
    bits(7, 0);
    chk("R5 none at 21", rec, 8);
    bits(1, 0);
    chk("R5 penalty at 22", tec, 16);
    bits(1, 1);
    bits(8, 0);
    chk("R5 run ended by recessive", tec, 16);
  endtask

  task automatic t_run_passive();
    do_reset();
    run_arm_pas = 1; tick();
    bits(7, 0);
    chk("R6 none at 7", rec, 0);
    bits(1, 0);
    chk("R6 penalty at 8", rec, 8);
    bits(8, 0);
    chk("R6 penalty at 16", tec, 16);
  endtask

  task automatic t_busoff();
    do_reset(); is_tx = 1;
    repeat (16) begin tx_err_evt = 1; tick(); end
    chk("R2 tec 128 passive", node_state, 1);
    repeat (15) begin tx_err_evt = 1; tick(); end
    chk("R2 tec 248 not busoff", node_state, 1);
    tx_err_evt = 1; tick();
    chk("R2 tec 256 busoff", node_state, 2);
    chk("R9 tx_inhibit", tx_inhibit, 1);
    chk("R10 busoff flag not dominant", flag_dominant, 0);
    rx_err_evt = 1; tx_ok_evt = 1; tick();
    chk("R9 tec frozen", tec, 256);
    chk("R9 rec frozen", rec, 0);
    bits(10, 1);
    bits(1, 0);
    bits(128 * 11 - 1, 1);
    chk("R9 still busoff one bit early", node_state, 2);
    bits(1, 1);
    chk("R9 recovered state", node_state, 0);
    chk("R9 recovered tec", tec, 0);
    chk("R9 recovered inhibit", tx_inhibit, 0);
  endtask

  task automatic t_suspend();
    do_reset(); is_tx = 1;
    repeat (16) begin tx_err_evt = 1; tick(); end
    own_tx_end = 1; tick();
    chk("R11 suspend raised", suspend_tx, 1);
    bits(7, 1);
    chk("R11 suspend after 7", suspend_tx, 1);
    bits(1, 1);
    chk("R11 suspend ends after 8", suspend_tx, 0);
    own_tx_end = 1; tick();
    bits(2, 1);
    bits(1, 0);
    chk("R11 dominant ends suspension", suspend_tx, 0);
    do_reset();
    own_tx_end = 1; tick();
    chk("R11 no suspension when active", suspend_tx, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    clr(); is_tx = 0; rst_n = 0;
    t_reset();
    t_rx_rules();
    t_tx_rules();
    t_combined();
    t_passive_clamp();
    t_rec_saturate();
    t_run_active();
    t_run_passive();
    t_busoff();
    t_suspend();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule